// File: doc/BRIEF.md
# Back-Channel Input Message Decoder

This block receives the serial return stream from a keyboard and mouse microcontroller. The stream carries one bit per scanline, and each bit is qualified by a sample strobe. The block parses each variable-length message in that stream. It sign-extends the two 4-bit mouse movement fields and adds them into 8-bit running totals. It keeps the most recent 6-bit button/status field, and it queues up to two optional 8-bit key events.

Nothing reaches the outputs while a field is being displayed. A single post strobe, issued once per vertical blanking interval, does the following:
- copies the movement totals and the button field to the outputs;
- clears the movement totals;
- hands out the oldest queued key event.

Queued events are therefore never lost and never presented twice.

A message begins with a 1 on the otherwise idle-low line. All fields arrive least significant bit first, in this order:
1. delta X, 4 bits;
2. delta Y, 4 bits;
3. the 6-bit button/status field;
4. one continuation bit, which chooses whether an 8-bit key code follows.

Top module: `bchan_msg_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero, the parser returns to idle and both the movement totals and the key queue empty.
- R2: In idle, a strobed 0 and any bit without `smp_en` leave all state unchanged; only a strobed 1 starts a message.
- R3: After the start bit, strobed bits form delta X (4 bits), then delta Y (4 bits), then the button/status field (6 bits), each least significant bit first.
- R4: Each delta is taken as 4-bit two's complement, sign-extended to 8 bits and added into its total modulo 256, accumulating across any number of messages between posts.
- R5: A post copies both totals to `dx_out`/`dy_out` and clears the totals; these outputs do not change without a post.
- R6: A post copies the most recently received button/status field to `btn_out`; the field is not cleared, and `btn_out` changes only on a post.
- R7: The bit after the button/status field ends the message when 0; when 1, the next 8 strobed bits form a key code (least significant first), after which the parser is idle.
- R8: Key codes queue in arrival order, at most two. A post with a non-empty queue sets `key_vld` to 1 and `key_out` to the oldest code and removes it. A post with an empty queue sets both to 0.
- R9: A key code arriving while two are already queued is discarded, the queue keeps its contents, and `key_ovf` goes to 1; the next post clears `key_ovf`.
- R10: Parser state is a 3-bit state plus a 5-bit bit counter whose carry-out ends each field; the state never takes values 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | One-cycle strobe qualifying `smp_bit` |
| smp_bit | input | 1 | Serial back-channel data bit |
| post_en | input | 1 | One-cycle vertical-blanking post strobe |
| dx_out | output | 8 | Posted X movement total |
| dy_out | output | 8 | Posted Y movement total |
| btn_out | output | 6 | Posted button/status field |
| key_vld | output | 1 | Posted key code is present |
| key_out | output | 8 | Posted key code, oldest first |
| key_ovf | output | 1 | A key code was discarded since the last post |

## Verification
The embedded properties check the following on every cycle:
- the parser never leaves its six legal states;
- an idle line does not start a message;
- a 0 continuation bit returns the parser to idle;
- the key queue never exceeds two entries, and a full queue holds and flags when another code arrives;
- the posted totals and the button field stay stable between posts;
- the totals clear when a post arrives alone.

Only the bench scenarios can show the remaining behaviour:
- correct bit ordering within each field;
- sign extension and modulo-256 wrap of the totals;
- oldest-first presentation of key codes across posts.

// File: rtl/bchan_pkg.sv
package bchan_pkg;

    localparam int DELTA_W = 4;
    localparam int BTN_W   = 6;
    localparam int KEY_W   = 8;
    localparam int ACC_W   = 8;
    localparam int CNT_W   = 5;
    localparam int SHR_W   = 8;
    localparam int KQ_DEPTH = 2;
    localparam int NUM_AXES = 2;

    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_DX   = 3'd1,
        PS_DY   = 3'd2,
        PS_BTN  = 3'd3,
        PS_FLAG = 3'd4,
        PS_KEY  = 3'd5
    } pstate_e;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_DX   = 3'd1,
        EV_DY   = 3'd2,
        EV_BTN  = 3'd3,
        EV_KEY  = 3'd4
    } evkind_e;

    typedef struct packed {
        evkind_e          kind;
        logic [SHR_W-1:0] data;
    } event_t;

    // Number of bits in the field collected in a given state.
    function automatic int field_len(pstate_e st);
        case (st)
            PS_DX, PS_DY: return DELTA_W;
            PS_BTN:       return BTN_W;
            PS_KEY:       return KEY_W;
            default:      return 1;
        endcase
    endfunction

    // Counter start value so that the last bit of a field produces a carry.
    function automatic logic [CNT_W-1:0] count_seed(int len);
        return CNT_W'((1 << CNT_W) - len);
    endfunction

    // Right-justified field value including the bit arriving now.
    function automatic logic [SHR_W-1:0] field_extract(logic [SHR_W-1:0] shr,
                                                      logic b, int len);
        logic [SHR_W-1:0] full;
        full = {b, shr[SHR_W-1:1]};
        return full >> (SHR_W - len);
    endfunction

endpackage

// File: rtl/bchan_parser.sv
module bchan_parser
    import bchan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_en,
    input  logic   smp_bit,
    output event_t evt
);

    pstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [SHR_W-1:0] shr_q, shr_d, fval;
    logic             carry;
    event_t           evt_d;

    always_comb begin
        {carry, cnt_inc} = {1'b0, cnt_q} + (CNT_W+1)'(1);
        fval       = field_extract(shr_q, smp_bit, field_len(st_q));
        st_d       = st_q;
        cnt_d      = cnt_q;
        shr_d      = shr_q;
        evt_d.kind = EV_NONE;
        evt_d.data = '0;
        if (smp_en) begin
            if (st_q == PS_IDLE) begin
                if (smp_bit) begin
                    st_d  = PS_DX;
                    cnt_d = count_seed(DELTA_W);
                end
            end else begin
                shr_d = {smp_bit, shr_q[SHR_W-1:1]};
                cnt_d = cnt_inc;
                if (carry) begin
                    evt_d.data = fval;
                    case (st_q)
                        PS_DX: begin
                            evt_d.kind = EV_DX;
                            st_d       = PS_DY;
                            cnt_d      = count_seed(DELTA_W);
                        end
                        PS_DY: begin
                            evt_d.kind = EV_DY;
                            st_d       = PS_BTN;
                            cnt_d      = count_seed(BTN_W);
                        end
                        PS_BTN: begin
                            evt_d.kind = EV_BTN;
                            st_d       = PS_FLAG;
                            cnt_d      = count_seed(1);
                        end
                        PS_FLAG: begin
                            st_d  = smp_bit ? PS_KEY : PS_IDLE;
                            cnt_d = count_seed(KEY_W);
                        end
                        PS_KEY: begin
                            evt_d.kind = EV_KEY;
                            st_d       = PS_IDLE;
                        end
                        default: st_d = PS_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= PS_IDLE;
            cnt_q    <= '0;
            shr_q    <= '0;
            evt.kind <= EV_NONE;
            evt.data <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            shr_q <= shr_d;
            evt   <= evt_d;
        end
    end

    // R10
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        st_q <= PS_KEY);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_IDLE && !(smp_en && smp_bit)) |=> st_q == PS_IDLE);

    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_IDLE && smp_en && smp_bit) |=> st_q == PS_DX);

    // R7
    flag_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_FLAG && smp_en && !smp_bit) |=> st_q == PS_IDLE);

endmodule

// File: rtl/bchan_delta_acc.sv
module bchan_delta_acc #(
    parameter int ACC_W   = 8,
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               add_en,
    input  logic [DELTA_W-1:0] delta,
    input  logic               clr,
    output logic [ACC_W-1:0]   post_q
);

    localparam int EXT_W = ACC_W - DELTA_W;

    logic [ACC_W-1:0] acc_q, acc_d, base, addend;

    always_comb begin
        base   = clr ? '0 : acc_q;
        addend = add_en ? {{EXT_W{delta[DELTA_W-1]}}, delta} : '0;
        acc_d  = base + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            post_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (clr) post_q <= acc_q;
        end
    end

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !add_en) |=> acc_q == '0);

    // R5
    post_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $stable(post_q));

    // R4
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !add_en) |=> $stable(acc_q));

endmodule

// File: rtl/bchan_key_queue.sv
module bchan_key_queue #(
    parameter int KEY_W = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [KEY_W-1:0] push_data,
    input  logic             pop,
    output logic             key_vld_q,
    output logic [KEY_W-1:0] key_q,
    output logic             ovf_q
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [KEY_W-1:0] slot_q [DEPTH];
    logic [KEY_W-1:0] slot_d [DEPTH];
    logic [CW-1:0]    cnt_q, cnt_d, base;
    logic             do_pop, drop;

    always_comb begin
        do_pop = pop && (cnt_q != '0);
        for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
        if (do_pop) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
            slot_d[DEPTH-1] = '0;
        end
        base = cnt_q - CW'(do_pop);
        drop = push && (base == CW'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            if (push && !drop && base == CW'(i)) slot_d[i] = push_data;
        end
        cnt_d = base + CW'(push && !drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            cnt_q     <= '0;
            key_vld_q <= 1'b0;
            key_q     <= '0;
            ovf_q     <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
            cnt_q <= cnt_d;
            if (pop) begin
                key_vld_q <= do_pop;
                key_q     <= do_pop ? slot_q[0] : '0;
                ovf_q     <= drop;
            end else begin
                ovf_q <= ovf_q | drop;
            end
        end
    end

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH) && ovf_q));

    // R8
    empty_post_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt_q == '0) |=> (!key_vld_q && key_q == '0));

endmodule

// File: rtl/bchan_msg_decoder.sv
module bchan_msg_decoder
    import bchan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic             smp_bit,
    input  logic             post_en,
    output logic [ACC_W-1:0] dx_out,
    output logic [ACC_W-1:0] dy_out,
    output logic [BTN_W-1:0] btn_out,
    output logic             key_vld,
    output logic [KEY_W-1:0] key_out,
    output logic             key_ovf
);

    event_t           evt;
    logic [ACC_W-1:0] axis_q [NUM_AXES];
    logic [BTN_W-1:0] btn_cur_q;

    bchan_parser u_parser (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .smp_bit (smp_bit),
        .evt     (evt)
    );

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        localparam evkind_e AX_KIND = (a == 0) ? EV_DX : EV_DY;
        bchan_delta_acc #(
            .ACC_W   (ACC_W),
            .DELTA_W (DELTA_W)
        ) u_acc (
            .clk    (clk),
            .rst    (rst),
            .add_en (evt.kind == AX_KIND),
            .delta  (evt.data[DELTA_W-1:0]),
            .clr    (post_en),
            .post_q (axis_q[a])
        );
    end

    assign dx_out = axis_q[0];
    assign dy_out = axis_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_cur_q <= '0;
            btn_out   <= '0;
        end else begin
            if (evt.kind == EV_BTN) btn_cur_q <= evt.data[BTN_W-1:0];
            if (post_en) btn_out <= btn_cur_q;
        end
    end

    bchan_key_queue #(
        .KEY_W (KEY_W),
        .DEPTH (KQ_DEPTH)
    ) u_keyq (
        .clk       (clk),
        .rst       (rst),
        .push      (evt.kind == EV_KEY),
        .push_data (evt.data[KEY_W-1:0]),
        .pop       (post_en),
        .key_vld_q (key_vld),
        .key_q     (key_out),
        .ovf_q     (key_ovf)
    );

    // R6
    btn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !post_en |=> $stable(btn_out));

endmodule

// File: tb/bchan_msg_decoder_tb.sv
module bchan_msg_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic       smp_bit = 1'b0;
    logic       post_en = 1'b0;
    logic [7:0] dx_out, dy_out, key_out;
    logic [5:0] btn_out;
    logic       key_vld, key_ovf;

    bchan_msg_decoder u_dut (
        .clk     (clk),
        .rst     (rst),
        .smp_en  (smp_en),
        .smp_bit (smp_bit),
        .post_en (post_en),
        .dx_out  (dx_out),
        .dy_out  (dy_out),
        .btn_out (btn_out),
        .key_vld (key_vld),
        .key_out (key_out),
        .key_ovf (key_ovf)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int         acc_x = 0;
    int         acc_y = 0;
    logic [5:0] exp_btn_cur = '0;
    logic [5:0] exp_btn_out = '0;
    logic [7:0] mq [2];
    int         mqn = 0;
    bit         exp_ovf = 0;

    // Fields: [23] post after, [22] key follows, [21:14] key, [13:8] buttons,
    // [7:4] delta Y, [3:0] delta X
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h00, 6'h25, 4'hE, 4'h3},
        {1'b0, 1'b1, 8'hA5, 6'h3F, 4'h7, 4'h8},
        {1'b1, 1'b0, 8'h00, 6'h12, 4'h1, 4'hF},
        {1'b0, 1'b1, 8'h01, 6'h00, 4'h0, 4'h7},
        {1'b1, 1'b1, 8'h80, 6'h08, 4'h8, 4'h7},
        {1'b1, 1'b0, 8'h00, 6'h08, 4'h0, 4'h0},
        {1'b1, 1'b0, 8'h00, 6'h01, 4'h1, 4'h1},
        {1'b0, 1'b1, 8'h11, 6'h2A, 4'h2, 4'h2},
        {1'b0, 1'b1, 8'h22, 6'h15, 4'h3, 4'hD},
        {1'b1, 1'b1, 8'h33, 6'h30, 4'h4, 4'h4}
    };

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        smp_bit = b;
        smp_en  = 1'b1;
        @(negedge clk);
        smp_en  = 1'b0;
        smp_bit = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_msg(input logic [3:0] dx, input logic [3:0] dy,
                            input logic [5:0] btn, input bit has_key,
                            input logic [7:0] key);
        send_bit(1'b1);
        for (int i = 0; i < 4; i++) send_bit(dx[i]);
        for (int i = 0; i < 4; i++) send_bit(dy[i]);
        for (int i = 0; i < 6; i++) send_bit(btn[i]);
        send_bit(has_key);
        if (has_key) for (int i = 0; i < 8; i++) send_bit(key[i]);
        acc_x = acc_x + $signed(dx);
        acc_y = acc_y + $signed(dy);
        exp_btn_cur = btn;
        if (has_key) begin
            if (mqn < 2) begin
                mq[mqn] = key;
                mqn++;
            end else begin
                exp_ovf = 1;
            end
        end
    endtask

    task automatic post_check(input string tag);
        bit         ev;
        logic [7:0] ek;
        chk(key_ovf == exp_ovf, {tag, " R9 overflow before post"},
            16'(key_ovf), 16'(exp_ovf));
        ev = (mqn > 0);
        ek = ev ? mq[0] : 8'h00;
        @(negedge clk);
        post_en = 1'b1;
        @(negedge clk);
        post_en = 1'b0;
        exp_btn_out = exp_btn_cur;
        chk(dx_out == 8'(acc_x), {tag, " R4 R5 dx"}, 16'(dx_out), 16'(8'(acc_x)));
        chk(dy_out == 8'(acc_y), {tag, " R4 R5 dy"}, 16'(dy_out), 16'(8'(acc_y)));
        chk(btn_out == exp_btn_out, {tag, " R3 R6 buttons"}, 16'(btn_out), 16'(exp_btn_out));
        chk(key_vld == ev, {tag, " R8 key valid"}, 16'(key_vld), 16'(ev));
        chk(key_out == ek, {tag, " R7 R8 key code"}, 16'(key_out), 16'(ek));
        chk(key_ovf == 1'b0, {tag, " R9 overflow cleared"}, 16'(key_ovf), 16'd0);
        acc_x = 0;
        acc_y = 0;
        if (ev) begin
            mq[0] = mq[1];
            mqn--;
        end
        exp_ovf = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mq[0] = '0;
        mq[1] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(dx_out == 8'h00, "R1 dx reset", 16'(dx_out), 16'h0);
        chk(dy_out == 8'h00, "R1 dy reset", 16'(dy_out), 16'h0);
        chk(btn_out == 6'h00, "R1 buttons reset", 16'(btn_out), 16'h0);
        chk(key_vld == 1'b0, "R1 key valid reset", 16'(key_vld), 16'h0);
        chk(key_out == 8'h00, "R1 key code reset", 16'(key_out), 16'h0);
        chk(key_ovf == 1'b0, "R1 overflow reset", 16'(key_ovf), 16'h0);

        // R2: idle noise has no effect
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        @(negedge clk);
        smp_bit = 1'b1;
        repeat (10) @(negedge clk);
        smp_bit = 1'b0;
        post_check("R2 idle noise");
        send_msg(4'h5, 4'h0, 6'h00, 1'b0, 8'h00);
        post_check("R2 frame alignment after noise");

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            send_msg(VEC[v][3:0], VEC[v][7:4], VEC[v][13:8], VEC[v][22], VEC[v][21:14]);
            if (VEC[v][23]) post_check($sformatf("vector %0d", v));
        end

        // R8: remaining queued code, then empty queue
        post_check("R8 drain second code");
        post_check("R8 empty queue");

        // R6: buttons persist across posts without new messages
        post_check("R6 buttons persist");

        // R4: accumulate across many messages with wrap
        for (int i = 0; i < 40; i++) send_msg(4'h7, 4'hF, 6'h2C, 1'b0, 8'h00);
        post_check("R4 wrap accumulate");

        // R10: a state beyond the key field never appears; a fresh message still decodes
        send_msg(4'hA, 4'h6, 6'h11, 1'b1, 8'h5C);
        post_check("R10 parser recovers to idle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule